// File: doc/BRIEF.md
# Serial Memory Command Slave

This block is the serial front end of a byte-wide memory with 2^17 locations that is backed by nonvolatile cells. A host selects it with an active-low select line and then clocks in one opcode, an optional 24-bit address and data, all most significant bit first. The block turns this traffic into single-cycle read and write requests on a synchronous SRAM port. It also keeps a small status register with a write-enable latch and block-protection bits, and it sends one-cycle request strobes to a separate store/recall sequencer.

All serial pins are sampled by the system clock through synchronizers. Input bits are taken on rising serial-clock edges and the output bit changes on falling edges. Because of this, a host that idles the serial clock low and a host that idles it high both work with no configuration. The select line is both edge and level qualified: one select period carries exactly one instruction. Bursts run for as long as select stays low, and the address wraps at the top of the array.

Top module: `spi_nvs_slave`

## Requirements
- R1: While `cs_ni` is high, `so_oe_o` is low and no memory request or strobe is issued. After reset the block ignores the bus until `cs_ni` has been seen high and then falls.
- R2: Bits move MSB first. SI is taken on rising `sck_i` edges and SO changes only after falling edges. This works whether `sck_i` idles low or high when select falls.
- R3: Opcode 0x06 sets the write-enable latch (WEN) and 0x04 clears it. Both take effect when `cs_ni` returns high.
- R4: Opcode 0x05 returns the status byte, repeated for as long as select stays low. The byte holds bit7 = protect-pin enable, bits3:2 = block-protect level, bit1 = WEN, bit0 = `nv_busy_i`, and zeros elsewhere.
- R5: Opcode 0x01 with WEN set loads bit7 and bits3:2 from the next byte. It is refused when bit7 is 1 and `wp_ni` is low. An accepted load clears WEN at the end of the select.
- R6: Opcode 0x03 takes three address bytes, and only bit 0 of the first byte is used as A16. The first data bit is driven after the falling edge that follows the last address bit. The burst then continues with the address incrementing and wrapping from 0x1FFFF to 0.
- R7: Opcode 0x02 with WEN set writes each following byte to the current address and then increments it, wrapping from 0x1FFFF to 0. WEN clears when select rises. Without WEN the instruction is ignored.
- R8: Protect level 01 blocks writes to 0x18000-0x1FFFF, level 10 blocks 0x10000-0x1FFFF and level 11 blocks all addresses. A blocked byte is not written, but the address still advances.
- R9: Opcodes 0x03 and 0x02 are refused while `nv_busy_i` is high.
- R10: With WEN set, opcodes 0x3C, 0x60, 0x59 and 0x19 each give one pulse on `store_o`, `recall_o`, `as_en_o` and `as_dis_o` respectively, and WEN clears when select rises. 0x3C and 0x60 also require `nv_busy_i` low.
- R11: Any other opcode (0x12, 0x13, 0x1E, unknown) is ignored together with the rest of its select period, and SO is not driven. A second opcode in the same select period is also ignored.
- R12: If select rises in the middle of a byte, the partial byte is discarded and the block waits for the next select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Select, active low |
| si_i | input | 1 | Serial data in |
| wp_ni | input | 1 | Write-protect pin, active low |
| nv_busy_i | input | 1 | Store/recall in progress |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO (high impedance when low) |
| mem_addr_o | output | ADDR_W | SRAM address |
| mem_rd_o | output | 1 | SRAM read request; data is due on the next cycle |
| mem_wr_o | output | 1 | SRAM write request |
| mem_wdata_o | output | 8 | SRAM write data |
| mem_rdata_i | input | 8 | SRAM read data |
| store_o | output | 1 | Store request strobe |
| recall_o | output | 1 | Recall request strobe |
| as_en_o | output | 1 | Auto-store enable strobe |
| as_dis_o | output | 1 | Auto-store disable strobe |

## Verification
The bench exercises the following corner cases:
- **Address wrap.** A burst crosses 0x1FFFF. A design that failed to wrap there would put the second byte outside the array, and a read-back at address 0 would return stale data.
- **Protection boundaries.** Writes land on both sides of each protection boundary. A wrong decode would either corrupt a protected byte or refuse a legal one.
- **Protect pin.** The pin is exercised with and without the enable bit. Ignoring the enable bit would lock the status register in systems that tie the pin low.
- **Select handling.** Select is held low through reset, an opcode is followed by a second opcode, and select is dropped in the middle of a byte. A block lacking edge qualification or per-select state would drive SO or write memory when it must not.
- **Busy input.** With busy high, reads and writes must be refused and store must not be requested, while status reads must still work.

// File: rtl/spi_nvs_pkg.sv
package spi_nvs_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_STORE  = 8'h3C;
  localparam logic [7:0] OP_RECALL = 8'h60;
  localparam logic [7:0] OP_ASEN   = 8'h59;
  localparam logic [7:0] OP_ASDIS  = 8'h19;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_RDSR, ST_WRSR, ST_SKIP
  } cmd_st_e;
endpackage

// File: rtl/spi_nvs_sync.sv
module spi_nvs_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] stg;
    logic              prev;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg  <= '0;
        prev <= 1'b0;
      end else begin
        stg  <= {stg[STAGES-2:0], d_i[b]};
        prev <= stg[STAGES-1];
      end
    end
    assign q_o[b]      = stg[STAGES-1];
    assign q_prev_o[b] = prev;
  end
endmodule

// File: rtl/spi_nvs_rx.sv
module spi_nvs_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic       done_o,
  output logic [7:0] byte_o
);
  logic [6:0] sh;
  logic [2:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clr_i) begin
      cnt <= '0;
    end else if (en_i) begin
      sh  <= {sh[5:0], bit_i};
      cnt <= cnt + 3'd1;
    end
  end

  assign done_o = en_i && (cnt == 3'd7);
  assign byte_o = {sh, bit_i};
endmodule

// File: rtl/spi_nvs_prot.sv
module spi_nvs_prot (
  input  logic [1:0] top_i,
  input  logic [1:0] lvl_i,
  output logic       hit_o
);
  always_comb begin
    case (lvl_i)
      2'b01:   hit_o = (top_i == 2'b11);
      2'b10:   hit_o = top_i[1];
      2'b11:   hit_o = 1'b1;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_nvs_slave.sv
module spi_nvs_slave
  import spi_nvs_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  input  logic              wp_ni,
  input  logic              nv_busy_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              store_o,
  output logic              recall_o,
  output logic              as_en_o,
  output logic              as_dis_o
);
  localparam int ACC_W = ADDR_W - 8;

  logic [3:0] pin_s, pin_p;
  logic sck_s, cs_s, si_s, wp_s, sck_p, cs_p;
  logic sck_rise, sck_fall, cs_fall, cs_rise, start;

  spi_nvs_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i      ({sck_i, cs_ni, si_i, wp_ni}),
    .q_o      (pin_s),
    .q_prev_o (pin_p)
  );

  assign {sck_s, cs_s, si_s, wp_s} = pin_s;
  assign sck_p    = pin_p[3];
  assign cs_p     = pin_p[2];
  assign sck_rise = sck_s & ~sck_p;
  assign sck_fall = ~sck_s & sck_p;
  assign cs_fall  = ~cs_s & cs_p;
  assign cs_rise  = cs_s & ~cs_p;

  cmd_st_e           st;
  logic              armed, wen, wpen, wen_set_p, wen_clr_p, is_wr;
  logic [1:0]        bp, abyte;
  logic [ACC_W-1:0]  acc;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        nxt, obuf, wdata, status_byte, rx_byte;
  logic [2:0]        ocnt;
  logic              so_q, so_act, rd_q, rd_pend, wr_q, wr_step;
  logic              st_q, rc_q, ae_q, ad_q, rx_done, prot_hit;

  assign start = cs_fall & armed;

  spi_nvs_rx u_rx (
    .clk_i, .rst_ni,
    .clr_i  (start),
    .en_i   (sck_rise && !cs_s && st != ST_IDLE),
    .bit_i  (si_s),
    .done_o (rx_done),
    .byte_o (rx_byte)
  );

  spi_nvs_prot u_prot (
    .top_i (addr[ADDR_W-1 -: 2]),
    .lvl_i (bp),
    .hit_o (prot_hit)
  );

  assign status_byte = {wpen, 3'b000, bp, wen, nv_busy_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE;
      armed <= 1'b0;
      wen <= 1'b0; wpen <= 1'b0; bp <= 2'b00;
      wen_set_p <= 1'b0; wen_clr_p <= 1'b0; is_wr <= 1'b0;
      abyte <= '0; acc <= '0; addr <= '0;
      nxt <= '0; obuf <= '0; wdata <= '0; ocnt <= '0;
      so_q <= 1'b0; so_act <= 1'b0;
      rd_q <= 1'b0; rd_pend <= 1'b0; wr_q <= 1'b0; wr_step <= 1'b0;
      st_q <= 1'b0; rc_q <= 1'b0; ae_q <= 1'b0; ad_q <= 1'b0;
    end else begin
      rd_q <= 1'b0; wr_q <= 1'b0; wr_step <= 1'b0;
      st_q <= 1'b0; rc_q <= 1'b0; ae_q <= 1'b0; ad_q <= 1'b0;
      rd_pend <= rd_q;
      if (rd_pend) nxt <= mem_rdata_i;
      if (wr_step) addr <= addr + ADDR_W'(1);
      if (cs_s) armed <= 1'b1;

      if (cs_s) begin
        st <= ST_IDLE;
        so_act <= 1'b0;
        so_q <= 1'b0;
        if (cs_rise) begin
          if (wen_set_p) wen <= 1'b1;
          if (wen_clr_p) wen <= 1'b0;
        end
        wen_set_p <= 1'b0;
        wen_clr_p <= 1'b0;
      end else if (start) begin
        st <= ST_OPC;
        abyte <= '0;
        ocnt <= '0;
        so_act <= 1'b0;
      end else begin
        if (st == ST_RDSR) nxt <= status_byte;
        if (rx_done) begin
          case (st)
            ST_OPC: begin
              st <= ST_SKIP;
              case (rx_byte)
                OP_WREN: wen_set_p <= 1'b1;
                OP_WRDI: wen_clr_p <= 1'b1;
                OP_RDSR: begin
                  st <= ST_RDSR;
                  nxt <= status_byte;
                end
                OP_WRSR:
                  if (wen && !(wpen && !wp_s)) st <= ST_WRSR;
                OP_READ:
                  if (!nv_busy_i) begin
                    st <= ST_ADDR; is_wr <= 1'b0;
                  end
                OP_WRITE:
                  if (wen && !nv_busy_i) begin
                    st <= ST_ADDR; is_wr <= 1'b1; wen_clr_p <= 1'b1;
                  end
                OP_STORE:
                  if (wen && !nv_busy_i) begin
                    st_q <= 1'b1; wen_clr_p <= 1'b1;
                  end
                OP_RECALL:
                  if (wen && !nv_busy_i) begin
                    rc_q <= 1'b1; wen_clr_p <= 1'b1;
                  end
                OP_ASEN:
                  if (wen) begin
                    ae_q <= 1'b1; wen_clr_p <= 1'b1;
                  end
                OP_ASDIS:
                  if (wen) begin
                    ad_q <= 1'b1; wen_clr_p <= 1'b1;
                  end
                default: ;
              endcase
            end
            ST_ADDR: begin
              acc <= ACC_W'({acc, rx_byte});
              abyte <= abyte + 2'd1;
              if (abyte == 2'd2) begin
                addr <= {acc, rx_byte};
                if (is_wr) st <= ST_WDATA;
                else begin
                  st <= ST_RDATA;
                  rd_q <= 1'b1;
                end
              end
            end
            ST_WDATA: begin
              wdata <= rx_byte;
              wr_q <= !prot_hit;
              wr_step <= 1'b1;
            end
            ST_WRSR: begin
              wpen <= rx_byte[7];
              bp <= rx_byte[3:2];
              wen_clr_p <= 1'b1;
              st <= ST_SKIP;
            end
            default: ;
          endcase
        end
        if (sck_fall && (st == ST_RDATA || st == ST_RDSR)) begin
          so_act <= 1'b1;
          ocnt <= ocnt + 3'd1;
          if (ocnt == 3'd0) begin
            so_q <= nxt[7];
            obuf <= {nxt[6:0], 1'b0};
            if (st == ST_RDATA) begin
              addr <= addr + ADDR_W'(1);
              rd_q <= 1'b1;
            end
          end else begin
            so_q <= obuf[7];
            obuf <= {obuf[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign so_o        = so_q;
  assign so_oe_o     = so_act;
  assign mem_addr_o  = addr;
  assign mem_rd_o    = rd_q;
  assign mem_wr_o    = wr_q;
  assign mem_wdata_o = wdata;
  assign store_o     = st_q;
  assign recall_o    = rc_q;
  assign as_en_o     = ae_q;
  assign as_dis_o    = ad_q;
endmodule

// File: rtl/spi_nvs_slave_chk.sv
module spi_nvs_slave_chk
  import spi_nvs_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              so_oe_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              store_o,
  input logic              recall_o,
  input logic              as_en_o,
  input logic              as_dis_o,
  input logic              nv_busy_i,
  input cmd_st_e           st,
  input logic              wen,
  input logic              prot_hit
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !so_oe_o);

  p_oe_states_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (st == ST_RDATA || st == ST_RDSR));

  p_rd_in_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (st == ST_RDATA));

  p_wr_needs_wen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> wen);

  p_wr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

  p_wr_unprot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> !prot_hit);

  p_one_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, store_o, recall_o, as_en_o, as_dis_o}));

  p_strobe_wen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o || recall_o || as_en_o || as_dis_o) |-> wen);

  p_nv_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o || recall_o) |-> !$past(nv_busy_i));
endmodule

bind spi_nvs_slave spi_nvs_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .so_oe_o    (so_oe_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_addr_o (mem_addr_o),
  .store_o    (store_o),
  .recall_o   (recall_o),
  .as_en_o    (as_en_o),
  .as_dis_o   (as_dis_o),
  .nv_busy_i  (nv_busy_i),
  .st         (st),
  .wen        (wen),
  .prot_hit   (prot_hit)
);

// File: tb/spi_nvs_slave_test.sv
module spi_nvs_slave_test;
  localparam int AW = 17;
  localparam int H  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, wp_n = 1'b1, busy = 1'b0;
  logic so, so_oe, mem_rd, mem_wr, store, recall, as_en, as_dis;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'h00;

  int checks = 0, errors = 0;
  int n_store = 0, n_recall = 0, n_asen = 0, n_asdis = 0;
  bit oe_seen = 0;
  bit mode3 = 0;
  logic [7:0] mem [int];

  always #4 clk = ~clk;

  spi_nvs_slave #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .wp_ni(wp_n), .nv_busy_i(busy), .so_o(so), .so_oe_o(so_oe),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .store_o(store), .recall_o(recall), .as_en_o(as_en), .as_dis_o(as_dis)
  );

  function automatic logic [7:0] dflt(int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : dflt(int'(mem_addr));
    if (store) n_store++;
    if (recall) n_recall++;
    if (as_en) n_asen++;
    if (as_dis) n_asdis++;
  end

  always @(negedge clk) if (so_oe) oe_seen = 1;

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sel();
    sck = mode3; wclk(4); cs_n = 1'b0; wclk(4);
  endtask

  task automatic desel();
    sck = mode3; wclk(4); cs_n = 1'b1; wclk(10);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = tx[i]; wclk(H);
      rx[i] = so;
      sck = 1'b1; wclk(H);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel(); xfer(8'h01, r); xfer(v, r); desel();
  endtask

  task automatic wr(input logic [23:0] a, input int n, input logic [23:0] d);
    logic [7:0] r;
    sel(); xfer(8'h02, r);
    xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) xfer(d[23-8*i -: 8], r);
    desel();
  endtask

  task automatic rd(input logic [23:0] a, input int n, output logic [23:0] got);
    logic [7:0] r;
    got = '0;
    sel(); xfer(8'h03, r);
    xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      got[23-8*i -: 8] = r;
    end
    desel();
  endtask

  task automatic t_reset();
    logic [7:0] r, s;
    // cs_n held low through reset: no falling edge seen, bus ignored
    wclk(5); rst_n = 1'b1; wclk(6);
    oe_seen = 0;
    xfer(8'h05, r); xfer(8'h00, r);
    chk("R1 no response without select edge", 32'(oe_seen), 0);
    sck = 1'b0; wclk(4); cs_n = 1'b1; wclk(10);
    chk("R1 deselected oe", 32'(so_oe), 0);
    rdsr(s);
    chk("R4 status after reset", 32'(s), 32'h00);
  endtask

  task automatic t_wen();
    logic [7:0] s, r, s2;
    cmd1(8'h06);
    sel(); xfer(8'h05, r); xfer(8'h00, s); xfer(8'h00, s2); desel();
    chk("R3 wren sets WEN", 32'(s), 32'h02);
    chk("R4 status repeats", 32'(s2), 32'h02);
    cmd1(8'h04);
    rdsr(s);
    chk("R3 wrdi clears WEN", 32'(s), 32'h00);
  endtask

  task automatic t_wrsr();
    logic [7:0] s;
    cmd1(8'h06); wrsr(8'h8C); rdsr(s);
    chk("R5 wrsr loads bits", 32'(s), 32'h8C);
    wp_n = 1'b0; wclk(4);
    cmd1(8'h06); wrsr(8'h00); rdsr(s);
    chk("R5 wrsr blocked by pin", 32'(s), 32'h8E);
    wp_n = 1'b1; wclk(4);
    wrsr(8'h00); rdsr(s);
    chk("R5 wrsr after pin release", 32'(s), 32'h00);
  endtask

  task automatic t_rw_modes();
    logic [23:0] g;
    logic [7:0] s;
    mode3 = 0; sck = 1'b0; wclk(4);
    cmd1(8'h06); wr(24'hFE0010, 3, 24'h112233);
    rdsr(s);
    chk("R7 WEN cleared after write", 32'(s), 32'h00);
    mode3 = 1; sck = 1'b1; wclk(4);
    rd(24'h000010, 3, g);
    chk("R2 R6 mode3 burst read, upper addr bits ignored", 32'(g), 32'h112233);
    mode3 = 0; sck = 1'b0; wclk(4);
  endtask

  task automatic t_wrap();
    logic [23:0] g;
    cmd1(8'h06); wr(24'h01FFFF, 2, 24'hAABB00);
    rd(24'h01FFFE, 3, g);
    chk("R6 R7 burst wraps to 0", 32'(g), 32'hA4AABB);
    wr(24'h000020, 1, 24'h770000);
    rd(24'h000020, 1, g);
    chk("R7 write ignored without WEN", 32'(g[23:16]), 32'(dflt(32'h20)));
  endtask

  task automatic t_protect();
    logic [23:0] g;
    logic [7:0] s;
    cmd1(8'h06); wrsr(8'h04); rdsr(s);
    chk("R8 level 01 set", 32'(s), 32'h04);
    cmd1(8'h06); wr(24'h017FFF, 2, 24'h010200);
    rd(24'h017FFF, 2, g);
    chk("R8 quarter boundary", 32'(g[23:8]), {16'h0, 8'h01, dflt(32'h18000)});
    cmd1(8'h06); wrsr(8'h08);
    cmd1(8'h06); wr(24'h00FFFF, 2, 24'h030400);
    rd(24'h00FFFF, 2, g);
    chk("R8 half boundary", 32'(g[23:8]), {16'h0, 8'h03, dflt(32'h10000)});
    cmd1(8'h06); wrsr(8'h0C);
    cmd1(8'h06); wr(24'h000100, 1, 24'h090000);
    rd(24'h000100, 1, g);
    chk("R8 full protect", 32'(g[23:16]), 32'(dflt(32'h100)));
    cmd1(8'h06); wrsr(8'h00); rdsr(s);
    chk("R8 protect cleared", 32'(s), 32'h00);
  endtask

  task automatic t_busy();
    logic [23:0] g;
    logic [7:0] s;
    busy = 1'b1; wclk(4);
    rdsr(s);
    chk("R4 busy bit", 32'(s), 32'h01);
    oe_seen = 0;
    rd(24'h000010, 1, g);
    chk("R9 read refused while busy", 32'(oe_seen), 0);
    cmd1(8'h06); wr(24'h000030, 1, 24'h550000);
    cmd1(8'h3C);
    chk("R10 store refused while busy", n_store, 0);
    busy = 1'b0; wclk(4);
    rdsr(s);
    chk("R9 WEN kept after refused write", 32'(s), 32'h02);
    rd(24'h000030, 1, g);
    chk("R9 write refused while busy", 32'(g[23:16]), 32'(dflt(32'h30)));
    cmd1(8'h3C);
    chk("R10 store strobe", n_store, 1);
    rdsr(s);
    chk("R10 WEN cleared after store", 32'(s), 32'h00);
  endtask

  task automatic t_special();
    cmd1(8'h60);
    chk("R10 recall needs WEN", n_recall, 0);
    cmd1(8'h06); cmd1(8'h60);
    chk("R10 recall strobe", n_recall, 1);
    cmd1(8'h06); cmd1(8'h59);
    chk("R10 autostore enable strobe", n_asen, 1);
    cmd1(8'h06); cmd1(8'h19);
    chk("R10 autostore disable strobe", n_asdis, 1);
  endtask

  task automatic t_invalid();
    logic [7:0] r, s;
    logic [23:0] g;
    cmd1(8'h06);
    oe_seen = 0;
    sel(); xfer(8'h1E, r); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r);
    xfer(8'h50, r); xfer(8'h99, r); desel();
    sel(); xfer(8'h13, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r); desel();
    chk("R11 invalid opcode leaves SO undriven", 32'(oe_seen), 0);
    rd(24'h000050, 1, g);
    chk("R11 data after invalid opcode ignored", 32'(g[23:16]), 32'(dflt(32'h50)));
    oe_seen = 0;
    sel(); xfer(8'h04, r); xfer(8'h05, r); xfer(8'h00, r); desel();
    chk("R11 second opcode ignored", 32'(oe_seen), 0);
    rdsr(s);
    chk("R11 first opcode still acted", 32'(s), 32'h00);
  endtask

  task automatic t_abort();
    logic [7:0] r, s;
    logic [23:0] g;
    cmd1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h40, r);
    xbits(8'hFF, 4, r); desel();
    rd(24'h000040, 1, g);
    chk("R12 partial byte discarded", 32'(g[23:16]), 32'(dflt(32'h40)));
    rdsr(s);
    chk("R12 next select decodes normally", 32'(s), 32'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_wen();
    t_wrsr();
    t_rw_modes();
    t_wrap();
    t_protect();
    t_busy();
    t_special();
    t_invalid();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule